// File: doc/BRIEF.md
# CPU Clock and Standby Controller

This block sets the CPU clock rate of a small microcontroller core and sequences its two standby states. The chip runs in one synchronous domain. The main oscillator and the slow subsystem oscillator each reach the block as a one-cycle tick input. The block returns a CPU clock-enable strobe, a main-derived peripheral clock-enable strobe and a subclock-derived peripheral strobe. It also returns the enable lines that start and stop both oscillators and the feedback-resistor switch.

Software controls the block through three byte registers on a simple write port with a separate read port. The clock register picks the main-clock divide and holds the main-oscillator stop bit. The oscillator register stops the subsystem oscillator and drops the feedback-resistor enable. The source register moves the CPU onto the subclock and picks its rate. A change of source or divide waits for the end of the CPU period that is running. HALT and STOP gate the CPU strobe. An interrupt request ends either state. Leaving STOP adds an oscillation-settling wait, counted in main ticks.

Top module: `cpu_clk_mgr`

## Requirements
- R1: After reset the registers read clock = 02h, oscillator = 00h and source = 00h, and the CPU strobe fires once per 8 main ticks.
- R2: While `rstN` is low, `mainOscEn` is low.
- R3: Bits [1:0] of the clock register (address 0) set the main-clock CPU period: 00 gives 1 tick, 01 gives 4 ticks, and 10 or 11 give 8 ticks.
- R4: Bit 4 of the source register (address 2) selects the subclock as the CPU source. Bit 0 of the same register sets the subclock period to 2 ticks when 1 and to 4 ticks when 0.
- R5: A new source or divide takes effect only at the boundary of the CPU period that is running. A boundary is the source tick that completes the period, and the CPU strobe fires on that cycle.
- R6: Bit 7 of the clock register takes a written 1 only while the subclock is the active CPU source and the source register still selects it. Otherwise the bit stays 0. While the bit is 1, `mainOscEn` is low. Writing the source register with bit 4 = 0 clears the bit.
- R7: Bit 0 of the oscillator register (address 1) drives `subOscEn` low, and bit 1 drives `fbResEn` low.
- R8: A `haltReq` pulse in run gates the CPU strobe off. A `wakeIrq` pulse ends HALT on the next edge.
- R9: A `stopReq` pulse enters STOP only while the main clock is the active source, and in STOP `mainOscEn` is low. While the subclock is active, a `stopReq` pulse is ignored. When `stopReq` and `haltReq` arrive together with the main clock active, STOP wins.
- R10: A `wakeIrq` pulse in STOP restarts the main oscillator. The CPU strobe then stays off for `SETTLE_TICKS` main ticks before run resumes.
- R11: `periClkEn` fires once per `PERI_DIV` main ticks that the oscillator passes, and it stays low while the main oscillator is stopped.
- R12: `subPeriClkEn` follows each subclock tick while the subsystem oscillator runs, in every standby state.
- R13: Read address 0, 1 and 2 return the clock, oscillator and source registers, and address 3 returns 00h. Reserved bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mainTick | input | 1 | One pulse per main oscillator period |
| subTick | input | 1 | One pulse per subsystem oscillator period |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 clock, 1 oscillator, 2 source |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data, combinational |
| haltReq | input | 1 | HALT request pulse |
| stopReq | input | 1 | STOP request pulse |
| wakeIrq | input | 1 | Enabled interrupt request, ends standby |
| cpuClkEn | output | 1 | CPU clock-enable strobe |
| periClkEn | output | 1 | Main-derived peripheral clock-enable strobe |
| subPeriClkEn | output | 1 | Subclock-derived strobe for the timer group |
| mainOscEn | output | 1 | Main oscillator run enable |
| subOscEn | output | 1 | Subsystem oscillator run enable |
| fbResEn | output | 1 | Feedback-resistor enable |

## Verification
A register write can land on the same cycle as a CPU period boundary. A write to the clock stop bit can land while a source switch is still pending. Random writes arrive on every twelfth cycle on average, against random tick patterns, so both collisions happen often. Directed sequences also line a divide write up against a known boundary. A cycle-level reference model in the bench applies the rule that the boundary latches the register values from before the write. Every output is compared with that model on every cycle, so the strobe must match on each cycle, not only on average.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_STOP   = 2'd2,
    ST_SETTLE = 2'd3
  } stbState_e;

  // control -> datapath strobes and pending configuration
  typedef struct packed {
    logic       mainOn;
    logic       subOn;
    logic       nextSub;
    logic       nextSubFast;
    logic [1:0] nextDivCode;
  } dpCtrl_t;

  localparam int          DATA_W    = 8;
  localparam int          PERIOD_W  = 4;
  localparam logic [1:0]  ADDR_CLK  = 2'd0;
  localparam logic [1:0]  ADDR_OSC  = 2'd1;
  localparam logic [1:0]  ADDR_SRC  = 2'd2;
  localparam logic [7:0]  CLK_MASK  = 8'h83;
  localparam logic [7:0]  OSC_MASK  = 8'h03;
  localparam logic [7:0]  SRC_MASK  = 8'h11;
  localparam logic [7:0]  CLK_RESET = 8'h02;

  function automatic logic [PERIOD_W-1:0] periodOf(input logic sub, input logic fast,
                                                   input logic [1:0] code);
    if (sub) return fast ? PERIOD_W'(2) : PERIOD_W'(4);
    case (code)
      2'd0:    return PERIOD_W'(1);
      2'd1:    return PERIOD_W'(4);
      default: return PERIOD_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/cpu_clk_datapath.sv
module cpu_clk_datapath
  import cpu_clk_pkg::*;
#(
  parameter int PERI_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    mainTick,
  input  logic    subTick,
  input  dpCtrl_t ctl,
  output logic    mainTickG,
  output logic    subTickG,
  output logic    boundary,
  output logic    activeSub,
  output logic    periClkEn
);

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] divVal;
  logic                srcSub;
  logic                srcTick;

  assign mainTickG = mainTick & ctl.mainOn;
  assign subTickG  = subTick & ctl.subOn;
  assign srcTick   = srcSub ? subTickG : mainTickG;
  assign boundary  = srcTick && (cnt == divVal - PERIOD_W'(1));
  assign activeSub = srcSub;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      divVal <= PERIOD_W'(8);
      srcSub <= 1'b0;
    end else if (srcTick) begin
      if (boundary) begin
        cnt    <= '0;
        srcSub <= ctl.nextSub;
        divVal <= periodOf(ctl.nextSub, ctl.nextSubFast, ctl.nextDivCode);
      end else begin
        cnt <= cnt + PERIOD_W'(1);
      end
    end
  end

  generate
    if (PERI_DIV <= 1) begin : g_periDirect
      assign periClkEn = mainTickG;
    end else begin : g_periCount
      localparam int PERI_W = $clog2(PERI_DIV);
      logic [PERI_W-1:0] periCnt;
      logic              periLast;
      assign periLast  = (periCnt == PERI_W'(PERI_DIV - 1));
      assign periClkEn = mainTickG & periLast;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          periCnt <= '0;
        else if (mainTickG) periCnt <= periLast ? '0 : periCnt + PERI_W'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/cpu_clk_control.sv
module cpu_clk_control
  import cpu_clk_pkg::*;
#(
  parameter int SETTLE_TICKS = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              haltReq,
  input  logic              stopReq,
  input  logic              wakeIrq,
  input  logic              boundary,
  input  logic              mainTickG,
  input  logic              activeSub,
  output dpCtrl_t           ctl,
  output stbState_e         state,
  output logic              cpuClkEn,
  output logic              mainOscEn,
  output logic              subOscEn,
  output logic              fbResEn
);

  localparam int SETTLE_W = $clog2(SETTLE_TICKS + 1);

  logic [DATA_W-1:0] clkReg;
  logic [DATA_W-1:0] oscReg;
  logic [DATA_W-1:0] srcReg;
  logic [SETTLE_W-1:0] settleCnt;
  logic settleDone;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkReg <= CLK_RESET;
      oscReg <= '0;
      srcReg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CLK: begin
          clkReg[6:0] <= wrData[6:0] & CLK_MASK[6:0];
          clkReg[7]   <= wrData[7] & activeSub & srcReg[4];
        end
        ADDR_OSC: oscReg <= wrData & OSC_MASK;
        ADDR_SRC: begin
          srcReg <= wrData & SRC_MASK;
          if (!wrData[4]) clkReg[7] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // standby sequencing
  assign settleDone = mainTickG && (settleCnt == SETTLE_W'(SETTLE_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      settleCnt <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (stopReq && !activeSub) state <= ST_STOP;
          else if (haltReq)          state <= ST_HALT;
        end
        ST_HALT: if (wakeIrq) state <= ST_RUN;
        ST_STOP: begin
          if (wakeIrq) begin
            state     <= ST_SETTLE;
            settleCnt <= '0;
          end
        end
        ST_SETTLE: begin
          if (settleDone)     state <= ST_RUN;
          else if (mainTickG) settleCnt <= settleCnt + SETTLE_W'(1);
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign mainOscEn = rstN & (state != ST_STOP) & ~clkReg[7];
  assign subOscEn  = ~oscReg[0];
  assign fbResEn   = ~oscReg[1];
  assign cpuClkEn  = boundary & (state == ST_RUN);

  assign ctl.mainOn      = mainOscEn;
  assign ctl.subOn       = subOscEn;
  assign ctl.nextSub     = srcReg[4];
  assign ctl.nextSubFast = srcReg[0];
  assign ctl.nextDivCode = clkReg[1:0];

  always_comb begin
    case (rdAddr)
      ADDR_CLK: rdData = clkReg;
      ADDR_OSC: rdData = oscReg;
      ADDR_SRC: rdData = srcReg;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/cpu_clk_mgr.sv
module cpu_clk_mgr
  import cpu_clk_pkg::*;
#(
  parameter int PERI_DIV     = 2,
  parameter int SETTLE_TICKS = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mainTick,
  input  logic       subTick,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [1:0] rdAddr,
  output logic [7:0] rdData,
  input  logic       haltReq,
  input  logic       stopReq,
  input  logic       wakeIrq,
  output logic       cpuClkEn,
  output logic       periClkEn,
  output logic       subPeriClkEn,
  output logic       mainOscEn,
  output logic       subOscEn,
  output logic       fbResEn
);

  dpCtrl_t   ctl;
  stbState_e stbState;
  logic      mainTickG;
  logic      subTickG;
  logic      boundary;
  logic      activeSub;

  cpu_clk_control #(.SETTLE_TICKS(SETTLE_TICKS)) u_ctrl (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .rdAddr, .rdData,
    .haltReq, .stopReq, .wakeIrq,
    .boundary, .mainTickG, .activeSub,
    .ctl, .state(stbState), .cpuClkEn, .mainOscEn, .subOscEn, .fbResEn
  );

  cpu_clk_datapath #(.PERI_DIV(PERI_DIV)) u_dp (
    .clk, .rstN, .mainTick, .subTick, .ctl,
    .mainTickG, .subTickG, .boundary, .activeSub, .periClkEn
  );

  assign subPeriClkEn = subTickG;

endmodule

// File: rtl/cpu_clk_mgr_chk.sv
module cpu_clk_mgr_chk
  import cpu_clk_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input stbState_e state,
  input logic      activeSub,
  input logic      boundary,
  input logic      cpuClkEn,
  input logic      periClkEn,
  input logic      subPeriClkEn,
  input logic      mainOscEn,
  input logic      subOscEn
);

  a_r2_osc_off_in_reset: assert property (@(posedge clk) !rstN |-> !mainOscEn);

  a_r5_source_held_mid_period: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(activeSub));

  a_r6_main_stop_needs_sub: assert property (@(posedge clk) disable iff (!rstN)
    (!mainOscEn && state != ST_STOP) |-> activeSub);

  a_r8_cpu_gated_in_standby: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN) |-> !cpuClkEn);

  a_r9_no_stop_on_sub: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && activeSub) |=> (state != ST_STOP));

  a_r9_stop_kills_main: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP) |-> !mainOscEn);

  a_r11_peri_needs_main: assert property (@(posedge clk) disable iff (!rstN)
    periClkEn |-> mainOscEn);

  a_r12_subperi_needs_sub: assert property (@(posedge clk) disable iff (!rstN)
    subPeriClkEn |-> subOscEn);

endmodule

bind cpu_clk_mgr cpu_clk_mgr_chk u_chk (
  .clk(clk), .rstN(rstN), .state(stbState), .activeSub(activeSub),
  .boundary(boundary), .cpuClkEn(cpuClkEn), .periClkEn(periClkEn),
  .subPeriClkEn(subPeriClkEn), .mainOscEn(mainOscEn), .subOscEn(subOscEn)
);

// File: tb/cpu_clk_mgr_test.sv
module cpu_clk_mgr_test;
  localparam int SETTLE = 16;
  localparam int PERI   = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, mainTick = 1'b0, subTick = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic haltReq = 1'b0, stopReq = 1'b0, wakeIrq = 1'b0;
  logic cpuClkEn, periClkEn, subPeriClkEn, mainOscEn, subOscEn, fbResEn;
  logic [7:0] rdData;

  cpu_clk_mgr #(.PERI_DIV(PERI), .SETTLE_TICKS(SETTLE)) uut (.*);

  // next-cycle stimulus, copied onto the ports at the falling edge
  logic nRst = 0, nMain = 0, nSub = 0, nWe = 0, nHalt = 0, nStop = 0, nWake = 0;
  logic [1:0] nWa = 0, nRa = 0;
  logic [7:0] nWd = 0;

  // sampled outputs of the last step
  logic sCpu, sPeri, sSubPeri, sMainOsc, sSubOsc, sFb;
  logic [7:0] sRd;

  int nChecks = 0, nFail = 0;

  // reference model
  logic [1:0] mDiv2; logic mStopBit; logic [1:0] mOsc; logic mSubSel, mSubFast;
  logic mSrcSub; int mPeriod, mCnt, mPeri, mState, mSettle;

  function automatic int periodFor(logic sub, logic fast, logic [1:0] code);
    if (sub) return fast ? 2 : 4;
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [7:0] rdModel(logic [1:0] a);
    case (a)
      2'd0: return {mStopBit, 5'b0, mDiv2};
      2'd1: return {6'b0, mOsc};
      2'd2: return {3'b0, mSubSel, 3'b0, mSubFast};
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelReset;
    mDiv2 = 2'b10; mStopBit = 0; mOsc = 0; mSubSel = 0; mSubFast = 0;
    mSrcSub = 0; mPeriod = 8; mCnt = 0; mPeri = 0; mState = 0; mSettle = 0;
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step;
    logic eMain, eSubOn, gMain, gSub, tick, bnd, oldSrc, oldSel, oldFast;
    logic [1:0] oldDiv;
    @(negedge clk);
    rstN = nRst; mainTick = nMain; subTick = nSub; wrEn = nWe; wrAddr = nWa;
    wrData = nWd; rdAddr = nRa; haltReq = nHalt; stopReq = nStop; wakeIrq = nWake;
    #1;
    if (!rstN) modelReset();
    eMain  = rstN && (mState != 2) && !mStopBit;
    eSubOn = !mOsc[0];
    gMain  = mainTick && eMain;
    gSub   = subTick && eSubOn;
    tick   = mSrcSub ? gSub : gMain;
    bnd    = tick && (mCnt == mPeriod - 1);
    check("cpuClkEn R3 R4 R5 R8 R10", {7'b0, cpuClkEn}, {7'b0, bnd && mState == 0});
    check("mainOscEn R2 R6 R9", {7'b0, mainOscEn}, {7'b0, eMain});
    check("periClkEn R11", {7'b0, periClkEn}, {7'b0, gMain && mPeri == PERI - 1});
    check("subPeriClkEn R12", {7'b0, subPeriClkEn}, {7'b0, gSub});
    check("osc enables R7", {6'b0, subOscEn, fbResEn}, {6'b0, eSubOn, !mOsc[1]});
    check("rdData R1 R13", rdData, rdModel(rdAddr));
    sCpu = cpuClkEn; sPeri = periClkEn; sSubPeri = subPeriClkEn;
    sMainOsc = mainOscEn; sSubOsc = subOscEn; sFb = fbResEn; sRd = rdData;
    @(posedge clk);
    if (rstN) begin
      oldSrc = mSrcSub; oldSel = mSubSel; oldFast = mSubFast; oldDiv = mDiv2;
      if (tick) begin
        if (bnd) begin
          mCnt = 0; mSrcSub = oldSel; mPeriod = periodFor(oldSel, oldFast, oldDiv);
        end else mCnt++;
      end
      if (gMain) mPeri = (mPeri == PERI - 1) ? 0 : mPeri + 1;
      case (mState)
        0: if (stopReq && !oldSrc) mState = 2; else if (haltReq) mState = 1;
        1: if (wakeIrq) mState = 0;
        2: if (wakeIrq) begin mState = 3; mSettle = 0; end
        default: if (gMain) begin
          if (mSettle == SETTLE - 1) mState = 0; else mSettle++;
        end
      endcase
      if (wrEn) begin
        case (wrAddr)
          2'd0: begin mDiv2 = wrData[1:0]; mStopBit = wrData[7] & oldSrc & oldSel; end
          2'd1: mOsc = wrData[1:0];
          2'd2: begin
            mSubSel = wrData[4]; mSubFast = wrData[0];
            if (!wrData[4]) mStopBit = 0;
          end
          default: ;
        endcase
      end
    end
  endtask

  task automatic idle;
    nRst = 1; nMain = 1; nSub = 0; nWe = 0; nHalt = 0; nStop = 0; nWake = 0;
  endtask

  task automatic writeReg(logic [1:0] a, logic [7:0] d);
    nWe = 1; nWa = a; nWd = d; step(); nWe = 0;
  endtask

  function automatic int countCpu(int n);
    return n;
  endfunction

  int cnt;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    modelReset();
    // reset state
    nRst = 0; nMain = 1; nRa = 2'd0;
    repeat (3) step();
    check("R2 main osc off in reset", {7'b0, sMainOsc}, 8'h00);
    check("R1 clock register reset value", sRd, 8'h02);
    idle();
    cnt = 0;
    for (int i = 0; i < 16; i++) begin step(); cnt += sCpu; end
    check("R1 default rate 2 strobes per 16 ticks", 8'(cnt), 8'd2);
    // divide change waits for boundary
    writeReg(2'd0, 8'h00);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin step(); cnt += sCpu; end
    check("R5 no early strobe after divide write", 8'(cnt), 8'd0);
    repeat (4) step();
    cnt = 0;
    for (int i = 0; i < 8; i++) begin step(); cnt += sCpu; end
    check("R3 divide-by-1 rate", 8'(cnt), 8'd8);
    // stop bit ignored while main active
    writeReg(2'd0, 8'h80);
    step();
    check("R6 stop bit refused on main", sRd, 8'h00);
    check("R6 main osc still on", {7'b0, sMainOsc}, 8'h01);
    // source register readback and reserved bits
    writeReg(2'd2, 8'hFF);
    nRa = 2'd2; step();
    check("R13 reserved bits read zero", sRd, 8'h11);
    nRa = 2'd3; step();
    check("R13 unused address reads zero", sRd, 8'h00);
    nRa = 2'd0;
    nSub = 1;
    repeat (6) step();
    writeReg(2'd0, 8'h80);
    step();
    check("R6 main osc stopped on sub", {7'b0, sMainOsc}, 8'h00);
    nStop = 1; step(); nStop = 0;
    cnt = 0;
    for (int i = 0; i < 4; i++) begin step(); cnt += sCpu; end
    check("R9 stop ignored on sub, R4 half rate", 8'(cnt), 8'd2);
    writeReg(2'd2, 8'h00);
    step();
    check("R6 source clear restarts main", {7'b0, sMainOsc}, 8'h01);
    repeat (6) step();
    nSub = 0;
    // oscillator register
    writeReg(2'd1, 8'h03);
    step();
    check("R7 sub osc and feedback off", {6'b0, sSubOsc, sFb}, 8'h00);
    writeReg(2'd1, 8'h00);
    // STOP and settle
    nStop = 1; step(); nStop = 0;
    step();
    check("R9 STOP stops main osc", {7'b0, sMainOsc}, 8'h00);
    repeat (3) step();
    nWake = 1; step(); nWake = 0;
    cnt = 0;
    for (int i = 0; i < SETTLE; i++) begin step(); cnt += sCpu; end
    check("R10 CPU held during settle", 8'(cnt), 8'd0);
    cnt = 0;
    for (int i = 0; i < 4; i++) begin step(); cnt += sCpu; end
    check("R10 CPU resumes after settle", 8'(cnt), 8'd4);
    // HALT with subclock peripherals alive
    nHalt = 1; step(); nHalt = 0;
    nSub = 1; cnt = 0;
    for (int i = 0; i < 5; i++) begin step(); cnt += sCpu + 8 * sSubPeri; end
    check("R8 no CPU strobe in HALT, R12 sub strobe runs", 8'(cnt), 8'd40);
    nSub = 0;
    nWake = 1; step(); nWake = 0;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin step(); cnt += sCpu + 16 * sPeri; end
    check("R8 wake resumes, R11 peripheral rate", 8'(cnt), 8'd72);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      nRst  = ($urandom_range(0, 499) != 0);
      nMain = ($urandom_range(0, 1) == 0);
      nSub  = ($urandom_range(0, 3) == 0);
      nWe   = ($urandom_range(0, 11) == 0);
      nWa   = 2'($urandom_range(0, 3));
      nWd   = 8'($urandom);
      nRa   = 2'($urandom_range(0, 3));
      nHalt = ($urandom_range(0, 39) == 0);
      nStop = ($urandom_range(0, 39) == 0);
      nWake = ($urandom_range(0, 9) == 0);
      step();
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule